// File: doc/BRIEF.md
# Serial Register Write Port

This block receives configuration writes over a three-wire serial link (clock, data, active-low select) and places them in a bank of 24-bit registers. Each frame opens with an 8-bit register address, then carries one or more 24-bit data words. Every field arrives least-significant bit first. A word is written only after all 24 of its bits have been shifted in. Each completed word moves the target address up by one, so one frame can fill a run of neighbouring registers.

Every write first lands in a shadow copy. A per-address mask parameter sorts the registers into two groups. Unmasked registers copy shadow to active when the select line closes the frame. Masked registers wait for a single-cycle sync strobe, which a line or frame timing event provides. The serial pins are sampled through two-flop synchronizers in the system clock domain. The active values are read combinationally through an address port by the logic that uses them.

Top module: `serial_cfg_regs`

## Requirements
- R1: While `sl_n` is low, each rising edge of `sck` captures one `sdi` bit. The first 8 bits form the address, LSB first. Each following group of 24 bits forms a data word, LSB first.
- R2: Rising edges of `sck` while `sl_n` is high have no effect. Raising `sl_n` returns the receiver to the address phase, so the next frame decodes from its first bit.
- R3: A word with fewer than 24 bits when `sl_n` rises is discarded. Its target register keeps its previous active value, even after a later sync strobe.
- R4: In one frame, the second and later complete words go to the address one above the previous word's address.
- R5: Auto-increment past address 0xFF wraps to address 0x00.
- R6: A register whose `SYNC_MASK` bit is 0 (by default addresses 0x00 to 0x0F) shows its newly written value on `rd_data` within 8 clock cycles after `sl_n` rises.
- R7: A register whose `SYNC_MASK` bit is 1 (by default addresses 0x10 to 0xFF) keeps its old active value when the frame ends. It takes the written value when `frame_sync` is pulsed high for one cycle.
- R8: A `frame_sync` pulse does not change registers whose mask bit is 0. A word written to such a register while the frame is still open stays hidden until `sl_n` rises.
- R9: After reset, every register reads 0 on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock; data captured on its rising edge |
| sdi | input | 1 | Serial data in |
| sl_n | input | 1 | Active-low frame select |
| frame_sync | input | 1 | Single-cycle commit strobe for sync-updated registers |
| rd_addr | input | 8 | Register index for readback of the active value |
| rd_data | output | 24 | Active value of the addressed register |

## Verification
Single-word frames go to both register groups. Their data patterns are asymmetric, with a lone bit set at the top or bottom of the word, so a reversed bit order or a one-bit misalignment changes the value read back. Multi-word frames start just below the group boundary and at the top address. These show whether the address steps by one, wraps to zero, and commits each word under the rule of its own group. Truncated words, stray serial clocks while the select line is idle, and a sync pulse during an open frame separate real commits from commits that happen too early or that should not happen.

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24,
  parameter logic [(1<<ADDR_W)-1:0] SYNC_MASK = {{((1<<ADDR_W)-16){1'b1}}, 16'h0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              sl_n,
  input  logic              frame_sync,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DATA_W);

  logic [1:0] sck_s, sdi_s, sln_s;
  logic       sck_d, sln_d;
  logic [CNT_W-1:0]  cnt;
  logic              in_data;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] shadow [NREG];
  logic [DATA_W-1:0] act    [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0; sdi_s <= '0; sln_s <= '1;
      sck_d <= 1'b0; sln_d <= 1'b1;
    end else begin
      sck_s <= {sck_s[0], sck};
      sdi_s <= {sdi_s[0], sdi};
      sln_s <= {sln_s[0], sl_n};
      sck_d <= sck_s[1];
      sln_d <= sln_s[1];
    end

  wire sel       = ~sln_s[1];
  wire bit_stb   = sel & sck_s[1] & ~sck_d;
  wire sl_end    = sln_s[1] & ~sln_d;
  wire [DATA_W-1:0] sh_nxt = {sdi_s[1], sh[DATA_W-1:1]};
  wire word_done = bit_stb & in_data & (cnt == CNT_W'(DATA_W-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; in_data <= 1'b0; waddr <= '0; sh <= '0;
    end else if (!sel) begin
      cnt <= '0; in_data <= 1'b0;
    end else if (bit_stb) begin
      sh <= sh_nxt;
      if (!in_data) begin
        if (cnt == CNT_W'(ADDR_W-1)) begin
          waddr   <= sh_nxt[DATA_W-1 -: ADDR_W];
          in_data <= 1'b1;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      end else if (word_done) begin
        cnt   <= '0;
        waddr <= waddr + 1'b1;
      end else cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) shadow[i] <= '0;
    end else if (word_done) shadow[waddr] <= sh_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) act[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if ((SYNC_MASK[i] && frame_sync) || (!SYNC_MASK[i] && sl_end))
          act[i] <= shadow[i];
    end

  assign rd_data = act[rd_addr];

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_data ? (cnt < CNT_W'(DATA_W)) : (cnt < CNT_W'(ADDR_W)));
  assert_idle_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0 && !in_data));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (waddr == $past(waddr) + ADDR_W'(1)));
  assert_addr_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && waddr == '1) |=> (waddr == '0));
  assert_hold_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(frame_sync) && !$past(sl_end) && $stable(rd_addr)) |-> $stable(rd_data));
  assert_sl_only_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sl_end) && !$past(frame_sync) && $stable(rd_addr) && SYNC_MASK[rd_addr])
      |-> $stable(rd_data));
  assert_sync_only_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_sync) && !$past(sl_end) && $stable(rd_addr) && !SYNC_MASK[rd_addr])
      |-> $stable(rd_data));
endmodule

// File: tb/serial_cfg_regs_tb.sv
module serial_cfg_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, sl_n = 1'b1, frame_sync = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [23:0] rd_data;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [23:0] mdl [256];

  always #10 clk = ~clk;

  serial_cfg_regs dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sl_n(sl_n),
    .frame_sync(frame_sync), .rd_addr(rd_addr), .rd_data(rd_data));

  // {address[31:24], data[23:0]}
  localparam logic [31:0] VEC [6] = '{32'h03A55A01, 32'h10123456, 32'h0F800001,
                                      32'hC7FEDCBA, 32'h00000001, 32'h80800000};

  task automatic check(input logic [7:0] a, input logic [23:0] exp, input string req);
    @(negedge clk) rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      failures++;
      $display("FAIL %s addr=%02h actual=%06h expected=%06h", req, a, rd_data, exp);
    end
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sdi = v[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    @(negedge clk) sl_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_frame();
    repeat (4) @(negedge clk);
    sl_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk) frame_sync = 1'b1;
    @(negedge clk) frame_sync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset state
    check(8'h00, 24'h0, "R9");
    check(8'h10, 24'h0, "R9");
    check(8'hFF, 24'h0, "R9");

    // R1 R6 R7 vector table
    for (int k = 0; k < 6; k++) begin
      logic [7:0]  a;
      logic [23:0] d;
      a = VEC[k][31:24];
      d = VEC[k][23:0];
      open_frame(); send({8'h00, d, a}, 32); close_frame();
      if (a < 8'h10) begin
        mdl[a] = d;
        check(a, mdl[a], "R6");
      end else begin
        check(a, mdl[a], "R7");
        pulse_sync();
        mdl[a] = d;
        check(a, mdl[a], "R7");
      end
    end

    // R2: stray serial clocks while idle
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) sdi = i[0];
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    open_frame(); send({8'h00, 24'h0F0F0F, 8'h05}, 32); close_frame();
    mdl[8'h05] = 24'h0F0F0F;
    check(8'h05, mdl[8'h05], "R2");

    // R3: partial word to unmasked and to masked register
    open_frame(); send({8'h00, 24'h7FFFFF, 8'h03}, 31); close_frame();
    check(8'h03, mdl[8'h03], "R3");
    open_frame(); send({8'h00, 24'h00FFFF, 8'h10}, 20); close_frame();
    pulse_sync();
    check(8'h10, mdl[8'h10], "R3");
    // R3: full word followed by a partial word
    open_frame(); send({24'h0, 8'h08}, 8); send({8'h0, 24'h111111}, 24);
    send({8'h0, 24'h222222}, 12); close_frame();
    mdl[8'h08] = 24'h111111;
    check(8'h08, mdl[8'h08], "R3");
    check(8'h09, mdl[8'h09], "R3");

    // R4: auto-increment across the group boundary
    open_frame(); send({24'h0, 8'h0E}, 8);
    send({8'h0, 24'hABC001}, 24); send({8'h0, 24'hABC002}, 24); send({8'h0, 24'hABC003}, 24);
    close_frame();
    mdl[8'h0E] = 24'hABC001; mdl[8'h0F] = 24'hABC002;
    check(8'h0E, mdl[8'h0E], "R4");
    check(8'h0F, mdl[8'h0F], "R4");
    check(8'h10, mdl[8'h10], "R7");
    pulse_sync();
    mdl[8'h10] = 24'hABC003;
    check(8'h10, mdl[8'h10], "R4");

    // R5: wrap from 0xFF to 0x00
    open_frame(); send({24'h0, 8'hFF}, 8);
    send({8'h0, 24'h5A5A5A}, 24); send({8'h0, 24'hC3C3C3}, 24); close_frame();
    mdl[8'h00] = 24'hC3C3C3;
    check(8'h00, mdl[8'h00], "R5");
    check(8'hFF, mdl[8'hFF], "R5");
    pulse_sync();
    mdl[8'hFF] = 24'h5A5A5A;
    check(8'hFF, mdl[8'hFF], "R5");

    // R8: sync pulse during open frame leaves unmasked register unchanged
    open_frame(); send({8'h00, 24'h900009, 8'h02}, 32);
    pulse_sync();
    check(8'h02, mdl[8'h02], "R8");
    close_frame();
    mdl[8'h02] = 24'h900009;
    check(8'h02, mdl[8'h02], "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule